// File: doc/BRIEF.md
# Chained Vector Pipeline Sequencer

This block sequences a short chain of vector operations, for instance a load followed by a scale and then an accumulate. Each stage of the chain is a fixed-latency pipeline that takes one element per clock once it runs. A downstream stage does not wait for its producer to finish the whole vector. It starts taking element i in the same cycle the producer's output strobe for element i appears. A read-after-write dependency between two stages therefore costs only the producer's latency, not a full vector time.

The arithmetic is replaced by pipelines that match the latency and carry only a valid bit. Software or a higher-level issue unit gives a vector length together with the start of the first stage. It then starts each later stage while that stage's source is running and has not yet delivered an element. The block reports a per-stage element strobe and a per-stage busy flag. It raises a completion pulse when the final stage has drained, and an error pulse when a start is refused. With the default latencies of 12, 7 and 6 cycles, a 64-element chain finishes in 90 cycles. Running the three operations one after another would take about 192 cycles.

Top module: `vchain_seq`

## Requirements
- R1: A start of stage 0 is accepted only when no stage is busy. On acceptance the vector length is captured, and any length above 64 is treated as 64.
- R2: After an accepted stage-0 start with length n > 0, the stage-0 strobe is high for exactly n consecutive cycles. The first of these comes 13 cycles after the cycle in which the start was high (issue register plus a 12-cycle load latency).
- R3: An element that enters stage k in cycle t appears on stage k's strobe in cycle t + L(k), with L(1) = 7 and L(2) = 6. Stage k passes on exactly the elements its source delivered while stage k was running.
- R4: A start of stage k > 0 is accepted only if stage k-1 is busy and has delivered no element in any earlier cycle. A start in the very cycle of the source's first strobe catches that element.
- R5: A refused start (stage 0 while any stage is busy, stage k already busy, or source not eligible) raises the error output for exactly the next cycle and changes no busy flag or strobe.
- R6: A stage's busy flag goes high in the cycle after its start is accepted. It goes low in the cycle after that stage's n-th strobe.
- R7: The completion output is high for one cycle, in the cycle after the last strobe of stage 2. A chain that does not include stage 2 produces no completion.
- R8: A stage-0 start with length 0 is accepted, raises the completion output in the next cycle, and sets no busy flag and no strobe.
- R9: For a full chain started within the allowed windows, the completion appears n + 26 cycles after the cycle holding the stage-0 start.
- R10: While synchronous reset is high, and in the cycle after it, all strobes, busy flags, completion and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vec_len | input | 7 | Vector length, sampled with a stage-0 start |
| stage_go | input | 3 | Per-stage start request, bit k starts stage k |
| elem_vld | output | 3 | Per-stage element output strobe |
| stage_busy | output | 3 | Per-stage running flag |
| chain_done | output | 1 | One-cycle completion pulse |
| seq_err | output | 1 | One-cycle pulse after a refused start |

## Verification
Two events can land in one cycle: a downstream start and the source stage's first output strobe. The design must both accept the start and take that element. The bench provokes this by watching for the first load strobe and raising the next stage's start in that same cycle, then doing the same for the final stage on the first scale strobe. It judges the result in three ways: the last stage must emit exactly n strobes, the completion must appear, and every cycle must match a timestamp-queue reference model. A start raised one cycle later is checked to be refused.

// File: rtl/vchain_pkg.sv
package vchain_pkg;

    localparam int unsigned VC_DEF_MAX_LEN = 64;

    // Status a stage controller publishes to its neighbours.
    typedef struct packed {
        logic armed;   // stage is running
        logic fresh;   // running and no element delivered yet
        logic last;    // this cycle carries the final element of the stage
    } stage_stat_t;

    function automatic int unsigned clamp_len(input int unsigned raw,
                                              input int unsigned lim);
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/vc_issue.sv
module vc_issue #(
    parameter int unsigned LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             active_o
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (go_i) begin
            rem_q <= len_i;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    assign active_o = (rem_q != '0);

    // R2: one element issued per clock, the remaining count drops by one
    p_issue_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rem_q != '0 && !go_i) |=> (rem_q == $past(rem_q) - LEN_W'(1)));

endmodule

// File: rtl/vc_lat_pipe.sv
module vc_lat_pipe #(
    parameter int unsigned LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_v,
    output logic out_v
);
    generate
        if (LAT <= 1) begin : g_single
            logic v_q;
            always_ff @(posedge clk) begin
                if (rst) v_q <= 1'b0;
                else     v_q <= in_v;
            end
            assign out_v = v_q;
        end else begin : g_chain
            logic [LAT-1:0] sr_q;
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[LAT-2:0], in_v};
            end
            assign out_v = sr_q[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/vc_stage_ctl.sv
module vc_stage_ctl
    import vchain_pkg::*;
#(
    parameter int unsigned LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             src_ok_i,
    input  logic             zero_i,
    input  logic [LEN_W-1:0] run_len_i,
    input  logic             out_v_i,
    output logic             accept_o,
    output logic             refuse_o,
    output stage_stat_t      stat_o
);
    logic             armed_q;
    logic [LEN_W-1:0] cnt_q;
    logic             last_el;

    assign accept_o = start_i && src_ok_i && !armed_q;
    assign refuse_o = start_i && !accept_o;
    assign last_el  = armed_q && out_v_i && (cnt_q == run_len_i - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (accept_o) begin
            armed_q <= !zero_i;
            cnt_q   <= '0;
        end else if (armed_q && out_v_i) begin
            if (last_el) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    assign stat_o.armed = armed_q;
    assign stat_o.fresh = armed_q && (cnt_q == '0);
    assign stat_o.last  = last_el;

    // R3: a stage only emits elements while it is running
    p_strobe_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        out_v_i |-> armed_q);

    // R6: the busy flag drops right after the final element
    p_disarm_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        last_el |=> !armed_q);

    // R5: a refused start leaves an idle stage idle
    p_refuse_keeps_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (refuse_o && !armed_q) |=> !armed_q);

endmodule

// File: rtl/vchain_seq.sv
module vchain_seq
    import vchain_pkg::*;
#(
    parameter int unsigned MAX_LEN    = VC_DEF_MAX_LEN,
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned LAT_W      = 8,
    parameter logic [NUM_STAGES*LAT_W-1:0] STAGE_LAT = {8'd6, 8'd7, 8'd12},
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned LAST      = NUM_STAGES - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEN_W-1:0]      vec_len,
    input  logic [NUM_STAGES-1:0] stage_go,
    output logic [NUM_STAGES-1:0] elem_vld,
    output logic [NUM_STAGES-1:0] stage_busy,
    output logic                  chain_done,
    output logic                  seq_err
);
    stage_stat_t             st [NUM_STAGES];
    logic [NUM_STAGES-1:0]   acc;
    logic [NUM_STAGES-1:0]   refused;
    logic [NUM_STAGES-1:0]   pipe_in;
    logic [NUM_STAGES-1:0]   src_ok;
    logic [NUM_STAGES-1:0]   armed_v;
    logic [LEN_W-1:0]        len_clamped;
    logic [LEN_W-1:0]        run_len_q;
    logic                    zero_len;
    logic                    issue_v;
    logic                    done_q;
    logic                    err_q;

    assign len_clamped = LEN_W'(clamp_len(32'(vec_len), MAX_LEN));
    assign zero_len    = (len_clamped == '0);

    always_ff @(posedge clk) begin
        if (rst)         run_len_q <= '0;
        else if (acc[0]) run_len_q <= len_clamped;
    end

    vc_issue #(.LEN_W(LEN_W)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .go_i     (acc[0] && !zero_len),
        .len_i    (len_clamped),
        .active_o (issue_v)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_STAGES; k++) begin : g_stage
            if (k == 0) begin : g_head
                assign src_ok[k]  = ~|armed_v;
                assign pipe_in[k] = issue_v;
            end else begin : g_chained
                assign src_ok[k]  = st[k-1].armed && st[k-1].fresh;
                assign pipe_in[k] = elem_vld[k-1] && (st[k].armed || acc[k]);
            end

            vc_lat_pipe #(.LAT(int'(STAGE_LAT[k*LAT_W +: LAT_W]))) u_pipe (
                .clk   (clk),
                .rst   (rst),
                .in_v  (pipe_in[k]),
                .out_v (elem_vld[k])
            );

            vc_stage_ctl #(.LEN_W(LEN_W)) u_ctl (
                .clk       (clk),
                .rst       (rst),
                .start_i   (stage_go[k]),
                .src_ok_i  (src_ok[k]),
                .zero_i    ((k == 0) ? zero_len : 1'b0),
                .run_len_i (run_len_q),
                .out_v_i   (elem_vld[k]),
                .accept_o  (acc[k]),
                .refuse_o  (refused[k]),
                .stat_o    (st[k])
            );

            assign armed_v[k] = st[k].armed;

            if (k > 0) begin : g_chk
                // R4: a downstream stage only starts while its source runs
                p_arm_needs_src_r4: assert property (@(posedge clk) disable iff (rst)
                    $rose(armed_v[k]) |-> $past(armed_v[k-1]));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= st[LAST].last || (acc[0] && zero_len);
            err_q  <= |refused;
        end
    end

    assign stage_busy = armed_v;
    assign chain_done = done_q;
    assign seq_err    = err_q;

    // R7: completion is reported only once the final stage has stopped
    p_done_after_idle_r7: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> !stage_busy[LAST]);

    // R8: a zero-length start leaves every stage idle
    p_zero_no_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (acc[0] && zero_len) |=> (stage_busy == '0));

endmodule

// File: tb/tb_vchain_seq.sv
module tb_vchain_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LAT0 = 12;
    localparam int LAT1 = 7;
    localparam int LAT2 = 6;
    localparam int QD   = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] vec_len = '0;
    logic [2:0] stage_go = '0;
    logic [2:0] elem_vld;
    logic [2:0] stage_busy;
    logic       chain_done;
    logic       seq_err;

    vchain_seq dut (
        .clk(clk), .rst(rst), .vec_len(vec_len), .stage_go(stage_go),
        .elem_vld(elem_vld), .stage_busy(stage_busy),
        .chain_done(chain_done), .seq_err(seq_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit mon_en = 0;
    bit finished = 0;

    // reference model: per-stage queues of output timestamps
    int qt [3][QD];
    int hd [3];
    int tl [3];
    bit a  [3];
    int c  [3];
    int mlen = 0;
    bit e_done = 0;
    bit e_err  = 0;
    bit evp [3];
    bit acc [3];
    int scnt [3];

    function automatic int lat_of(int k);
        return (k == 0) ? LAT0 : (k == 1) ? LAT1 : LAT2;
    endfunction

    task automatic push(int k, int t);
        qt[k][tl[k] % QD] = t;
        tl[k] = tl[k] + 1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int n;
        cyc = cyc + 1;
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                a[k] = 0; c[k] = 0; hd[k] = 0; tl[k] = 0;
            end
            e_done = 0; e_err = 0;
        end else begin
            for (int k = 0; k < 3; k++)
                evp[k] = (hd[k] < tl[k]) && (qt[k][hd[k] % QD] == cyc - 1);
            acc[0] = stage_go[0] && !a[0] && !a[1] && !a[2];
            for (int k = 1; k < 3; k++)
                acc[k] = stage_go[k] && !a[k] && a[k-1] && (c[k-1] == 0);
            e_err = 0;
            for (int k = 0; k < 3; k++)
                if (stage_go[k] && !acc[k]) e_err = 1;
            e_done = 0;
            for (int k = 1; k < 3; k++)
                if (evp[k-1] && (a[k] || acc[k])) push(k, cyc - 1 + lat_of(k));
            for (int k = 0; k < 3; k++) begin
                if (evp[k]) begin
                    hd[k] = hd[k] + 1;
                    c[k]  = c[k] + 1;
                    if (c[k] == mlen) begin
                        a[k] = 0; c[k] = 0;
                        if (k == 2) e_done = 1;
                    end
                end
            end
            for (int k = 1; k < 3; k++)
                if (acc[k]) begin a[k] = 1; c[k] = 0; end
            if (acc[0]) begin
                n = (int'(vec_len) > 64) ? 64 : int'(vec_len);
                if (n == 0) e_done = 1;
                else begin
                    mlen = n; a[0] = 1; c[0] = 0;
                    for (int i = 0; i < n; i++) push(0, cyc + LAT0 + i);
                end
            end
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 3; k++) if (elem_vld[k]) scnt[k]++;
        end
        if (mon_en && !rst) begin
            for (int k = 0; k < 3; k++) begin
                bit ev;
                ev = (hd[k] < tl[k]) && (qt[k][hd[k] % QD] == cyc);
                chk(elem_vld[k] == ev, (k == 0) ? "R2" : "R3", "strobe", elem_vld[k], ev);
                chk(stage_busy[k] == a[k], "R6", "busy", stage_busy[k], a[k]);
            end
            chk(chain_done == e_done, "R7", "done", chain_done, e_done);
            chk(seq_err == e_err, "R5", "error", seq_err, e_err);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(logic [2:0] m, int len);
        stage_go = m;
        vec_len  = len[6:0];
        @(negedge clk);
        stage_go = '0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (stage_busy != 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        step(3);
    endtask

    task automatic run_chain(int n);
        int s, d, guard, b2;
        b2 = scnt[2];
        s = cyc;
        go(3'b001, n);
        go(3'b010, n);
        go(3'b100, n);
        guard = 0;
        while (!chain_done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        d = cyc;
        chk(d - s == n + 26, "R9", "start-to-done cycles", d - s, n + 26);
        wait_idle();
        chk(scnt[2] - b2 == n, "R3", "final stage element count", scnt[2] - b2, n);
    endtask

    initial begin
        int b0, b2, guard;
        for (int k = 0; k < 3; k++) scnt[k] = 0;
        step(3);
        // R10: reset state, during reset
        chk(elem_vld == 0 && stage_busy == 0, "R10", "outputs in reset", {elem_vld, stage_busy}, 0);
        chk(!chain_done && !seq_err, "R10", "pulses in reset", {chain_done, seq_err}, 0);
        rst = 1'b0;
        step(1);
        chk(elem_vld == 0 && stage_busy == 0 && !chain_done && !seq_err,
            "R10", "outputs after reset", {elem_vld, stage_busy, chain_done, seq_err}, 0);
        mon_en = 1;

        // full chains, several lengths
        run_chain(8);
        run_chain(1);
        run_chain(64);

        // R1: length clamp
        b0 = scnt[0];
        go(3'b001, 100);
        wait_idle();
        chk(scnt[0] - b0 == 64, "R1", "clamped length strobes", scnt[0] - b0, 64);

        // R8: zero length
        go(3'b001, 0);
        chk(chain_done == 1'b1, "R8", "zero length done", chain_done, 1);
        chk(stage_busy == 0, "R8", "zero length busy", stage_busy, 0);
        step(3);

        // R5: refusals
        go(3'b010, 5);
        chk(seq_err == 1'b1, "R5", "start without source", seq_err, 1);
        chk(stage_busy == 0, "R5", "no busy after refusal", stage_busy, 0);
        go(3'b001, 5);
        go(3'b001, 9);
        chk(seq_err == 1'b1, "R1", "stage 0 restart while busy", seq_err, 1);
        go(3'b100, 5);
        chk(seq_err == 1'b1, "R5", "final stage before middle", seq_err, 1);
        chk(stage_busy == 3'b001, "R5", "busy unchanged", stage_busy, 1);
        wait_idle();

        // R4: downstream starts in the exact cycle of the first source strobe
        b2 = scnt[2];
        go(3'b001, 10);
        guard = 0;
        while (!elem_vld[0] && guard < 100) begin @(negedge clk); guard++; end
        go(3'b010, 10);
        guard = 0;
        while (!elem_vld[1] && guard < 100) begin @(negedge clk); guard++; end
        go(3'b100, 10);
        guard = 0;
        while (!chain_done && guard < 200) begin @(negedge clk); guard++; end
        chk(chain_done == 1'b1, "R4", "same-cycle chain completes", chain_done, 1);
        wait_idle();
        chk(scnt[2] - b2 == 10, "R4", "same-cycle chain count", scnt[2] - b2, 10);

        // R4: a start one cycle after the first source strobe is refused
        go(3'b001, 6);
        guard = 0;
        while (!elem_vld[0] && guard < 100) begin @(negedge clk); guard++; end
        step(1);
        go(3'b010, 6);
        chk(seq_err == 1'b1, "R4", "late downstream start", seq_err, 1);
        chk(stage_busy[1] == 1'b0, "R4", "late start not armed", stage_busy[1], 0);
        wait_idle();

        run_chain(3);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule